// File: doc/BRIEF.md
# Low-Power One-Shot Compare Timer

This block is a small timer whose counter runs from a slow kernel clock, while software reaches it through a register port on a faster bus clock. A power-of-two prescaler sets the length of one counter tick. A compare value sets when the timer fires. A single-shot start request makes the counter run once from zero. When the count moves past the compare value, the counter stops, a match flag is set on the bus side and, if enabled, an interrupt is raised.

The two clock domains are joined by toggle handshakes. A compare write is captured on the bus side and loaded into the kernel domain. When the kernel domain acknowledges the load, a write-done flag is set. The start request travels the same way. Match events come back as a toggle that sets a sticky flag. Setting the run bit does not make the timer ready at once: it becomes ready only after two prescaled ticks. A start that arrives earlier is held until then.

The register port is word addressed. All fields are 16 bits wide or less:

| Index | Register | Fields |
|---|---|---|
| 0 | control | bit 0 run (read/write), bit 1 start (write 1 to request a start, reads 0) |
| 1 | configuration | bits 2:0 prescaler select |
| 2 | compare | bits 15:0 compare value |
| 3 | interrupt enable | bit 0 |
| 4 | status (read only) | bit 0 match flag, bit 1 compare-done flag |
| 5 | clear (write only) | write 1 to bit 0 or bit 1 to clear the matching status flag |

Top module: `lp_oneshot_timer`

## Requirements
- R1: The prescaler select, held in bits 2:0 of configuration register index 1, gives a tick length of 2^sel kernel clocks, for sel from 0 (divide by 1) to 7 (divide by 128). The value written reads back from the same register.
- R2: After a start, the match occurs as the counter leaves the compare value N. That is exactly (N+1) prescaled ticks after the counter begins.
- R3: In single-shot operation the counter stops after one match. Without a new start request, no second match occurs.
- R4: After the run bit (bit 0 of index 0) goes from 0 to 1, the timer accepts a start only after 2 prescaled ticks. A start written together with the run bit is held and launched once that delay has passed.
- R5: A write to the compare register (index 2) is ignored, and its readback is unchanged, while the run bit is 0 or while an earlier compare handover is still in progress. An ignored write sets no done flag.
- R6: An accepted compare write sets status bit 1 once the kernel domain has acknowledged the new value. Writing 1 to bit 1 of the clear register (index 5) clears the flag.
- R7: A match sets status bit 0. Writing 1 to bit 0 of the clear register clears it. The irq output equals the match flag ANDed with bit 0 of interrupt-enable register index 3.
- R8: Clearing the run bit stops and resets the counter and drops any held start, so a run that was in progress produces no match. The compare value is kept.
- R9: A write to the prescaler select while the run bit is 1 is ignored, and its readback is unchanged.
- R10: A start request that arrives while the counter is running is ignored. The match still occurs at the time set by the first start.
- R11: After reset, every readable register returns 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register port clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| kern_clk | input | 1 | Slow kernel clock that drives the counter |
| kern_rst | input | 1 | Synchronous active-high reset, kernel domain |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| irq | output | 1 | Match interrupt, gated by the enable bit |

## Verification
The bench measures the delay from a start write to irq in kernel clocks, for random and directed pairs of compare value and prescaler. Counting one tick too few or too many, or applying the divider to the wrong event, moves the result out of a narrow window. An enable-plus-start case shows whether the two-tick ready delay is present; a design without it fires two ticks early. A second start sent during a run, a disable in the middle of a run, and compare or prescaler writes made in the locked state each catch a design that retriggers, fires after being stopped, or lets a locked field change. The done flag and the interrupt gate are checked around their clear writes.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    localparam int CNT_W      = 16;
    localparam int DATA_W     = CNT_W;
    localparam int ADDR_W     = 3;
    localparam int PSEL_W     = 3;
    localparam int PCNT_W     = (1 << PSEL_W) - 1;
    localparam int ARM_TICKS  = 2;
    localparam int ARM_W      = 2;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL = 3'd0,
        RA_CFG  = 3'd1,
        RA_CMP  = 3'd2,
        RA_IEN  = 3'd3,
        RA_STAT = 3'd4,
        RA_CLR  = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic              run_en;
        logic [PSEL_W-1:0] psel;
        logic [CNT_W-1:0]  cmp;
        logic              ien;
    } bus_cfg_t;

    typedef struct packed {
        logic shot_tgl;
        logic req_tgl;
        logic run_en;
    } b2k_t;

    typedef struct packed {
        logic ack_tgl;
        logic match_tgl;
    } k2b_t;

    function automatic logic [PCNT_W-1:0] div_mask(input logic [PSEL_W-1:0] sel);
        logic [PCNT_W:0] one_hot;
        one_hot = (PCNT_W+1)'(1) << sel;
        return PCNT_W'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lpt_bus_regs.sv
module lpt_bus_regs
    import lpt_pkg::*;
(
    input  logic              bclk,
    input  logic              brst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output bus_cfg_t          cfg,
    output logic              shot_tgl,
    output logic              req_tgl,
    input  k2b_t              k2b_s
);
    logic f_match, f_cmpok, busy;
    logic ack_prev, match_prev;
    logic ack_edge, match_edge;

    assign ack_edge   = k2b_s.ack_tgl ^ ack_prev;
    assign match_edge = k2b_s.match_tgl ^ match_prev;

    always_ff @(posedge bclk) begin
        if (brst) begin
            cfg        <= '0;
            f_match    <= 1'b0;
            f_cmpok    <= 1'b0;
            busy       <= 1'b0;
            ack_prev   <= 1'b0;
            match_prev <= 1'b0;
            shot_tgl   <= 1'b0;
            req_tgl    <= 1'b0;
        end else begin
            ack_prev   <= k2b_s.ack_tgl;
            match_prev <= k2b_s.match_tgl;
            if (ack_edge) begin
                busy    <= 1'b0;
                f_cmpok <= 1'b1;
            end
            if (match_edge) f_match <= 1'b1;
            if (reg_we) begin
                case (reg_addr)
                    RA_CTRL: begin
                        cfg.run_en <= reg_wdata[0];
                        if (reg_wdata[1]) shot_tgl <= ~shot_tgl;
                    end
                    RA_CFG: if (!cfg.run_en) cfg.psel <= reg_wdata[PSEL_W-1:0];
                    RA_CMP: if (cfg.run_en && !busy) begin
                        cfg.cmp <= reg_wdata[CNT_W-1:0];
                        busy    <= 1'b1;
                        req_tgl <= ~req_tgl;
                    end
                    RA_IEN: cfg.ien <= reg_wdata[0];
                    RA_CLR: begin
                        if (reg_wdata[0] && !match_edge) f_match <= 1'b0;
                        if (reg_wdata[1] && !ack_edge)   f_cmpok <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: reg_rdata[0]          = cfg.run_en;
            RA_CFG:  reg_rdata[PSEL_W-1:0] = cfg.psel;
            RA_CMP:  reg_rdata             = cfg.cmp;
            RA_IEN:  reg_rdata[0]          = cfg.ien;
            RA_STAT: reg_rdata[1:0]        = {f_cmpok, f_match};
            default: reg_rdata = '0;
        endcase
    end

    assign irq = f_match & cfg.ien;

    a_r5_cmp_locked_when_off: assert property (@(posedge bclk) disable iff (brst)
        (reg_we && reg_addr == RA_CMP && !cfg.run_en) |=> $stable(cfg.cmp));

    a_r9_psel_locked_when_on: assert property (@(posedge bclk) disable iff (brst)
        (reg_we && reg_addr == RA_CFG && cfg.run_en) |=> $stable(cfg.psel));

    a_r6_done_needs_ack: assert property (@(posedge bclk) disable iff (brst)
        $rose(f_cmpok) |-> $past(ack_edge));

    a_r7_match_clear: assert property (@(posedge bclk) disable iff (brst)
        (reg_we && reg_addr == RA_CLR && reg_wdata[0] && !match_edge) |=> !f_match);
endmodule

// File: rtl/lpt_kern_core.sv
module lpt_kern_core
    import lpt_pkg::*;
(
    input  logic              kclk,
    input  logic              krst,
    input  logic              run_en_s,
    input  logic [PSEL_W-1:0] psel,
    input  logic              shot_tgl_s,
    input  logic              req_tgl_s,
    input  logic [CNT_W-1:0]  cmp_bus,
    output logic              ack_tgl,
    output logic              match_tgl
);
    logic [PCNT_W-1:0] pcnt;
    logic [ARM_W-1:0]  arm_cnt;
    logic [CNT_W-1:0]  cnt, cmp_k;
    logic armed, running, pending;
    logic shot_prev, req_prev;
    logic shot_edge, req_edge, tick;

    assign shot_edge = shot_tgl_s ^ shot_prev;
    assign req_edge  = req_tgl_s ^ req_prev;
    assign tick      = (pcnt & div_mask(psel)) == div_mask(psel);

    always_ff @(posedge kclk) begin
        if (krst) begin
            pcnt      <= '0;
            arm_cnt   <= '0;
            cnt       <= '0;
            cmp_k     <= '0;
            armed     <= 1'b0;
            running   <= 1'b0;
            pending   <= 1'b0;
            shot_prev <= 1'b0;
            req_prev  <= 1'b0;
            ack_tgl   <= 1'b0;
            match_tgl <= 1'b0;
        end else begin
            shot_prev <= shot_tgl_s;
            req_prev  <= req_tgl_s;
            if (req_edge) begin
                cmp_k   <= cmp_bus;
                ack_tgl <= ~ack_tgl;
            end
            if (!run_en_s) begin
                pcnt    <= '0;
                arm_cnt <= '0;
                cnt     <= '0;
                armed   <= 1'b0;
                running <= 1'b0;
                pending <= 1'b0;
            end else begin
                pcnt <= pcnt + 1'b1;
                if (!armed) begin
                    if (tick) begin
                        arm_cnt <= arm_cnt + 1'b1;
                        if (arm_cnt == ARM_W'(ARM_TICKS - 1)) armed <= 1'b1;
                    end
                    if (shot_edge) pending <= 1'b1;
                end else if (!running) begin
                    if (pending || shot_edge) begin
                        running <= 1'b1;
                        cnt     <= '0;
                        pcnt    <= '0;
                        pending <= 1'b0;
                    end
                end else if (tick) begin
                    if (cnt == cmp_k) begin
                        running   <= 1'b0;
                        cnt       <= '0;
                        match_tgl <= ~match_tgl;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    a_r4_start_needs_arm: assert property (@(posedge kclk) disable iff (krst)
        $rose(running) |-> $past(armed));

    a_r3_stop_on_match: assert property (@(posedge kclk) disable iff (krst)
        (match_tgl != $past(match_tgl)) |-> !running);

    a_r8_disable_resets: assert property (@(posedge kclk) disable iff (krst)
        !run_en_s |=> (!running && !armed && cnt == '0));

    a_r2_match_on_leave: assert property (@(posedge kclk) disable iff (krst)
        (run_en_s && running && tick && cnt == cmp_k) |=> (match_tgl != $past(match_tgl)));
endmodule

// File: rtl/lp_oneshot_timer.sv
module lp_oneshot_timer
    import lpt_pkg::*;
(
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic              kern_clk,
    input  logic              kern_rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    bus_cfg_t cfg;
    b2k_t     b2k, b2k_s;
    k2b_t     k2b, k2b_s;
    logic     shot_tgl, req_tgl;

    assign b2k = '{shot_tgl: shot_tgl, req_tgl: req_tgl, run_en: cfg.run_en};

    lpt_bus_regs u_bus (
        .bclk      (bus_clk),
        .brst      (bus_rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .cfg       (cfg),
        .shot_tgl  (shot_tgl),
        .req_tgl   (req_tgl),
        .k2b_s     (k2b_s)
    );

    lpt_sync #(.W($bits(b2k_t)), .STAGES(SYNC_STAGES)) u_sync_b2k (
        .clk (kern_clk),
        .rst (kern_rst),
        .d   (b2k),
        .q   (b2k_s)
    );

    lpt_sync #(.W($bits(k2b_t)), .STAGES(SYNC_STAGES)) u_sync_k2b (
        .clk (bus_clk),
        .rst (bus_rst),
        .d   (k2b),
        .q   (k2b_s)
    );

    lpt_kern_core u_core (
        .kclk       (kern_clk),
        .krst       (kern_rst),
        .run_en_s   (b2k_s.run_en),
        .psel       (cfg.psel),
        .shot_tgl_s (b2k_s.shot_tgl),
        .req_tgl_s  (b2k_s.req_tgl),
        .cmp_bus    (cfg.cmp),
        .ack_tgl    (k2b.ack_tgl),
        .match_tgl  (k2b.match_tgl)
    );
endmodule

// File: tb/lp_oneshot_timer_bench.sv
module lp_oneshot_timer_bench;
    localparam int BUS_PERIOD  = 10;
    localparam int KERN_PERIOD = 4 * BUS_PERIOD;
    localparam int WATCHDOG    = 150000;

    logic        bus_clk = 0, kern_clk = 0, bus_rst = 1, kern_rst = 1;
    logic        reg_we = 0;
    logic [2:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_chk = 0, n_bad = 0;

    always #(BUS_PERIOD/2)  bus_clk  = ~bus_clk;
    always #(KERN_PERIOD/2) kern_clk = ~kern_clk;

    lp_oneshot_timer u_lp_oneshot_timer (
        .bus_clk(bus_clk), .bus_rst(bus_rst), .kern_clk(kern_clk), .kern_rst(kern_rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic int exp_delay(input int n, input int sel);
        return (n + 1) << sel;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_win(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge bus_clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge bus_clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        @(negedge bus_clk);
        reg_addr = a;
        #1 d = int'(reg_rdata);
    endtask

    task automatic wait_k(input int n);
        repeat (n) @(negedge kern_clk);
    endtask

    task automatic measure(output int k);
        k = 0;
        while (!irq && k < 40000) begin
            @(negedge kern_clk);
            k++;
        end
    endtask

    // disable, set prescaler, enable, load compare, wait until ready
    task automatic setup(input int sel, input int n);
        int v, t;
        wr(0, 0); wait_k(4);
        wr(1, 16'(sel));
        wr(0, 1);
        wr(2, 16'(n));
        t = 0; v = 0;
        while (!v[1] && t < 100) begin rd(4, v); t++; end
        chk("R6 compare done flag", v[1], 1);
        wr(5, 3);
        wait_k(2 * (1 << sel) + 8);
    endtask

    task automatic shot_run(input int sel, input int n);
        int k, e;
        setup(sel, n);
        wr(0, 3);
        measure(k);
        e = exp_delay(n, sel);
        chk_win($sformatf("R2 R1 delay sel=%0d n=%0d", sel, n), k, e + 1, e + 7);
        wr(5, 1);
    endtask

    initial begin
        int v, k, e;
        void'($urandom(32'h1234_5eed));
        repeat (4) @(negedge kern_clk);
        bus_rst = 0; kern_rst = 0;

        // R11 reset state
        for (int a = 0; a < 5; a++) begin rd(3'(a), v); chk($sformatf("R11 reg %0d", a), v, 0); end
        chk("R11 irq", int'(irq), 0);

        // R5 compare ignored while disabled
        wr(2, 16'd5); wait_k(10);
        rd(2, v); chk("R5 cmp readback off", v, 0);
        rd(4, v); chk("R5 no done flag", v[1], 0);

        // R1 and R9 prescaler select
        wr(1, 16'd6); rd(1, v); chk("R1 psel readback", v, 6);
        wr(0, 1); wr(1, 16'd2); rd(1, v); chk("R9 psel locked", v, 6);

        // R5 busy lock, R6 done and clear
        wr(2, 16'd9); wr(2, 16'd7);
        rd(2, v); chk("R5 cmp busy ignore", v, 9);
        wait_k(10);
        rd(4, v); chk("R6 done set", v[1], 1);
        wr(5, 2); rd(4, v); chk("R6 done cleared", v[1], 0);

        // directed corner cases and random pairs for R2 and R1
        wr(3, 1);
        shot_run(0, 0);
        shot_run(7, 3);
        shot_run(4, 127);
        for (int i = 0; i < 10; i++) shot_run(int'($urandom_range(0, 4)), int'($urandom_range(0, 30)));

        // R3 no second match
        shot_run(1, 10);
        wait_k(3 * exp_delay(10, 1) + 20);
        rd(4, v); chk("R3 no second match", v[0], 0);

        // R4 start together with enable
        setup(4, 5);
        wr(0, 0); wait_k(6);
        wr(0, 3);
        measure(k);
        e = exp_delay(5, 4) + 2 * 16;
        chk_win("R4 enable delay", k, e + 1, e + 8);
        wr(5, 1);

        // R10 start during run ignored
        setup(0, 60);
        wr(0, 3);
        fork
            measure(k);
            begin wait_k(20); wr(0, 3); end
        join
        e = exp_delay(60, 0);
        chk_win("R10 retrigger ignored", k, e + 1, e + 7);
        wr(5, 1);
        wait_k(150);
        rd(4, v); chk("R10 single match", v[0], 0);

        // R8 disable mid-run
        setup(2, 100);
        wr(0, 3);
        wait_k(100);
        wr(0, 0);
        wait_k(600);
        rd(4, v); chk("R8 no match after disable", v[0], 0);
        chk("R8 irq low", int'(irq), 0);
        rd(2, v); chk("R8 compare kept", v, 100);

        // R7 interrupt gating
        wr(3, 0);
        setup(1, 8);
        wr(0, 3);
        wait_k(exp_delay(8, 1) + 20);
        rd(4, v); chk("R7 flag set", v[0], 1);
        chk("R7 irq gated off", int'(irq), 0);
        wr(3, 1); rd(4, v);
        chk("R7 irq on", int'(irq), 1);
        wr(5, 1); rd(4, v);
        chk("R7 flag cleared", v[0], 0);
        chk("R7 irq after clear", int'(irq), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge bus_clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule